// File: doc/BRIEF.md
# Switch Management Register Bank

This block is the register file that a management processor uses to watch and configure a multi-port Ethernet switch controller. The processor reaches it through a request channel that follows valid/ready rules: address, write flag, write data. Reads come back on a response channel one cycle after the request is taken. The block keeps two sticky event registers that clear themselves when read: an interrupt-cause register and a system-error register. It shows live per-port status words, and it holds sixteen read/write configuration words that are brought out as one flat bus for the switch logic.

The cause bits, gated by an interrupt-enable word, drive a level interrupt output. The top half of the 6-bit address space does not live here. An access there is passed to an external PHY management port, with the PHY register number equal to the address minus 32. The request channel stalls until that port acknowledges.

Back-pressure rules: the requester holds valid, write flag, address and data steady until it sees ready high at a clock edge. Local addresses are always ready. PHY-window addresses are ready only in the cycle the PHY port acknowledges. The response channel has no ready: a response is valid for exactly one cycle and the requester must take it.

Top module: `sw_mgmt_regs`

## Requirements
- R1: After reset the cause and error registers read 0, every configuration word reads 0 (the system word reads its default value, 0 by default), and irq_o is low.
- R2: A pulse on init_done_i, partition_evt_i or arl_irq_i sets cause bit 0, 2 or 3 at address 1. The bit stays set until address 1 is read. Cause bits 7..4 always read 0.
- R3: A read of address 1 or address 2 returns the register's value before that cycle's events, then clears it. An event in the same cycle as the clearing read is kept, and the next read returns it.
- R4: A pulse on bist_fail_i sets error bit 0 at address 2. Cause bit 1 is set in the same cycle only if bit 0 of the error-enable word at address 30 is 1.
- R5: irq_o is high exactly when some cause bit is set whose bit is also set in the interrupt-enable word at address 17.
- R6: Addresses 16..31 are read/write words. Each keeps only its own width of the written data; higher bits read 0. Widths: 16 is 16 bits, 17 is 8, 23 is 4, 24 is 5, 25 is 19, 28 is 5, 30 is 8, 31 is 4, and the rest are NP bits.
- R7: Writes to addresses 0..15 change no register. Reads of addresses 0 and 6..15 return 0.
- R8: Reads of addresses 3, 4 and 5 return the live inputs part_status_i, phy_err_status_i and activity_i.
- R9: A request to address 32..63 raises phy_req_o with phy_reg_o equal to the address minus 32. It holds req_ready_o low until phy_ack_i, passes the low 16 bits of write data out, and returns phy_rdata_i zero-extended on a read.
- R10: rsp_valid_o is high for one cycle, the cycle after each accepted read. It is never high after a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Request accepted at this edge |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 6 | Register address |
| req_wdata_i | input | DW | Write data |
| rsp_valid_o | output | 1 | Read data valid (one cycle) |
| rsp_rdata_o | output | DW | Read data |
| init_done_i | input | 1 | Initialization-complete event |
| partition_evt_i | input | 1 | Port-partition event |
| arl_irq_i | input | 1 | Address-table interrupt event |
| bist_fail_i | input | 1 | Self-test failure event |
| part_status_i | input | NP | Per-port partition status |
| phy_err_status_i | input | NP | Per-port PHY management error status |
| activity_i | input | NP | Per-port activity |
| irq_o | output | 1 | Masked interrupt request |
| cfg_o | output | 16*DW | Configuration words, word k at bits k*DW +: DW |
| phy_req_o | output | 1 | PHY access request |
| phy_write_o | output | 1 | PHY access is a write |
| phy_reg_o | output | 5 | PHY register number |
| phy_wdata_o | output | 16 | PHY write data |
| phy_ack_i | input | 1 | PHY access done |
| phy_rdata_i | input | 16 | PHY read data |

## Verification
A lost or stuck sticky bit shows up on the very next read of address 1 or 2. It also shows on irq_o in the cycle after the event, because the output follows the stored bits with no added register. A wrong clear-versus-set priority can only be seen when an event lands on the same edge as the clearing read, so the bench lines those two up on purpose. A decode or width fault in the configuration words shows up in the read data one cycle after the read, and on cfg_o right after the write. A PHY handshake fault shows as a missing stall, a wrong register number, or a response sent without its data.

// File: rtl/sw_mgmt_pkg.sv
package sw_mgmt_pkg;
  localparam int AW       = 6;
  localparam int NCFG     = 16;
  localparam int PHY_RW   = 5;
  localparam int PHY_DW   = 16;
  localparam int IDX_IMSK = 1;   // address 17
  localparam int IDX_EMSK = 14;  // address 30

  typedef enum logic [2:0] {
    SEL_NONE, SEL_CAUSE, SEL_ERR, SEL_PART, SEL_PMERR, SEL_ACT, SEL_CFG, SEL_PHY
  } sel_e;

  // stored width of configuration word idx (address 16 + idx)
  function automatic int cfg_width(input int idx, input int np, input int dw);
    int w;
    case (idx)
      0:       w = 16;
      1:       w = 8;
      7:       w = 4;
      8:       w = 5;
      9:       w = 19;
      12:      w = 5;
      14:      w = 8;
      15:      w = 4;
      default: w = np;
    endcase
    return (w > dw) ? dw : w;
  endfunction
endpackage

// File: rtl/sw_mgmt_decode.sv
module sw_mgmt_decode
  import sw_mgmt_pkg::*;
(
  input  logic [AW-1:0] addr_i,
  output sel_e          sel_o
);
  always_comb begin
    sel_o = SEL_NONE;
    if (addr_i[5])      sel_o = SEL_PHY;
    else if (addr_i[4]) sel_o = SEL_CFG;
    else begin
      case (addr_i[3:0])
        4'd1:    sel_o = SEL_CAUSE;
        4'd2:    sel_o = SEL_ERR;
        4'd3:    sel_o = SEL_PART;
        4'd4:    sel_o = SEL_PMERR;
        4'd5:    sel_o = SEL_ACT;
        default: sel_o = SEL_NONE;
      endcase
    end
  end
endmodule

// File: rtl/sw_mgmt_sticky.sv
module sw_mgmt_sticky #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic         clr_i,
  output logic [W-1:0] q_o
);
  // set wins over clear so an event on the clearing edge survives
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_o <= '0;
    else        q_o <= (clr_i ? '0 : q_o) | set_i;
  end
endmodule

// File: rtl/sw_mgmt_cfg.sv
module sw_mgmt_cfg
  import sw_mgmt_pkg::*;
#(
  parameter int DW         = 24,
  parameter int NP         = 24,
  parameter int SYSCFG_RST = 0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               we_i,
  input  logic [3:0]         idx_i,
  input  logic [DW-1:0]      wdata_i,
  output logic [NCFG*DW-1:0] cfg_o
);
  for (genvar i = 0; i < NCFG; i++) begin : g_word
    localparam int            W    = cfg_width(i, NP, DW);
    localparam logic [DW-1:0] MASK = {DW{1'b1}} >> (DW - W);
    localparam logic [DW-1:0] RST  = (i == 0) ? (DW'(SYSCFG_RST) & MASK) : '0;
    logic [DW-1:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      q <= RST;
      else if (we_i && idx_i == 4'(i)) q <= wdata_i & MASK;
    end
    assign cfg_o[i*DW +: DW] = q;
  end
endmodule

// File: rtl/sw_mgmt_regs.sv
module sw_mgmt_regs
  import sw_mgmt_pkg::*;
#(
  parameter int DW         = 24,
  parameter int NP         = 24,
  parameter int SYSCFG_RST = 0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid_i,
  output logic               req_ready_o,
  input  logic               req_write_i,
  input  logic [5:0]         req_addr_i,
  input  logic [DW-1:0]      req_wdata_i,
  output logic               rsp_valid_o,
  output logic [DW-1:0]      rsp_rdata_o,
  input  logic               init_done_i,
  input  logic               partition_evt_i,
  input  logic               arl_irq_i,
  input  logic               bist_fail_i,
  input  logic [NP-1:0]      part_status_i,
  input  logic [NP-1:0]      phy_err_status_i,
  input  logic [NP-1:0]      activity_i,
  output logic               irq_o,
  output logic [16*DW-1:0]   cfg_o,
  output logic               phy_req_o,
  output logic               phy_write_o,
  output logic [4:0]         phy_reg_o,
  output logic [15:0]        phy_wdata_o,
  input  logic               phy_ack_i,
  input  logic [15:0]        phy_rdata_i
);
  sel_e        sel;
  logic        fire, rd_fire;
  logic [7:0]  cause_set, err_set, cause_q, err_q;
  logic [7:0]  intmask_q, errmask_q;
  logic        err_hit;
  logic [DW-1:0] rd_mux;

  sw_mgmt_decode u_dec (.addr_i(req_addr_i), .sel_o(sel));

  // request handshake: local words always ready, PHY window waits for ack
  assign req_ready_o = (sel != SEL_PHY) || phy_ack_i;
  assign fire        = req_valid_i && req_ready_o;
  assign rd_fire     = fire && !req_write_i;

  assign phy_req_o   = req_valid_i && (sel == SEL_PHY);
  assign phy_write_o = req_write_i;
  assign phy_reg_o   = req_addr_i[4:0];
  assign phy_wdata_o = req_wdata_i[15:0];

  sw_mgmt_cfg #(.DW(DW), .NP(NP), .SYSCFG_RST(SYSCFG_RST)) u_cfg (
    .clk     (clk),
    .rst_n   (rst_n),
    .we_i    (fire && req_write_i && sel == SEL_CFG),
    .idx_i   (req_addr_i[3:0]),
    .wdata_i (req_wdata_i),
    .cfg_o   (cfg_o)
  );

  assign intmask_q = cfg_o[IDX_IMSK*DW +: 8];
  assign errmask_q = cfg_o[IDX_EMSK*DW +: 8];

  assign err_set   = {7'b0, bist_fail_i};
  assign err_hit   = |(err_set & errmask_q);
  assign cause_set = {4'b0, arl_irq_i, partition_evt_i, err_hit, init_done_i};

  sw_mgmt_sticky #(.W(8)) u_cause (
    .clk(clk), .rst_n(rst_n), .set_i(cause_set),
    .clr_i(rd_fire && sel == SEL_CAUSE), .q_o(cause_q)
  );

  sw_mgmt_sticky #(.W(8)) u_err (
    .clk(clk), .rst_n(rst_n), .set_i(err_set),
    .clr_i(rd_fire && sel == SEL_ERR), .q_o(err_q)
  );

  assign irq_o = |(cause_q & intmask_q);

  always_comb begin
    case (sel)
      SEL_CAUSE: rd_mux = DW'(cause_q);
      SEL_ERR:   rd_mux = DW'(err_q);
      SEL_PART:  rd_mux = DW'(part_status_i);
      SEL_PMERR: rd_mux = DW'(phy_err_status_i);
      SEL_ACT:   rd_mux = DW'(activity_i);
      SEL_CFG:   rd_mux = cfg_o[req_addr_i[3:0]*DW +: DW];
      SEL_PHY:   rd_mux = DW'(phy_rdata_i);
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid_o <= 1'b0;
      rsp_rdata_o <= '0;
    end else begin
      rsp_valid_o <= rd_fire;
      if (rd_fire) rsp_rdata_o <= rd_mux;
    end
  end
endmodule

// File: rtl/sw_mgmt_regs_chk.sv
module sw_mgmt_regs_chk #(
  parameter int DW = 24
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid_i,
  input logic             req_ready_o,
  input logic             req_write_i,
  input logic [5:0]       req_addr_i,
  input logic             rsp_valid_o,
  input logic             init_done_i,
  input logic             irq_o,
  input logic [16*DW-1:0] cfg_o,
  input logic             phy_req_o,
  input logic [4:0]       phy_reg_o,
  input logic             phy_ack_i,
  input logic [7:0]       cause_q
);
  logic acc_rd, acc_wr;
  assign acc_rd = req_valid_i && req_ready_o && !req_write_i;
  assign acc_wr = req_valid_i && req_ready_o && req_write_i;

  p_stall_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_i && req_addr_i[5] && !phy_ack_i) |-> !req_ready_o);

  p_phy_reg_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_i && req_addr_i[5]) |-> (phy_req_o && phy_reg_o == req_addr_i[4:0]));

  p_rsp_after_rd_r10: assert property (@(posedge clk) disable iff (!rst_n)
    acc_rd |=> rsp_valid_o);

  p_no_rsp_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_rd |=> !rsp_valid_o);

  p_clear_keep_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_rd && req_addr_i == 6'd1) |=>
      (cause_q[7:4] == 4'b0 && cause_q[0] == $past(init_done_i)));

  p_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cause_q[0] && !(acc_rd && req_addr_i == 6'd1)) |=> cause_q[0]);

  p_irq_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cause_q == 8'b0) |-> !irq_o);

  p_ro_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_wr && req_addr_i[5:4] == 2'b00) |=> $stable(cfg_o));
endmodule

bind sw_mgmt_regs sw_mgmt_regs_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid_i(req_valid_i), .req_ready_o(req_ready_o),
  .req_write_i(req_write_i), .req_addr_i(req_addr_i), .rsp_valid_o(rsp_valid_o),
  .init_done_i(init_done_i), .irq_o(irq_o), .cfg_o(cfg_o), .phy_req_o(phy_req_o),
  .phy_reg_o(phy_reg_o), .phy_ack_i(phy_ack_i), .cause_q(cause_q)
);

// File: tb/test_sw_mgmt_regs.sv
`timescale 1ns/1ps
module test_sw_mgmt_regs;
  localparam int DW = 24;
  localparam int NP = 24;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0;
  logic [5:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic req_ready, rsp_valid, irq;
  logic [DW-1:0] rsp_rdata;
  logic ev_init = 0, ev_part = 0, ev_arl = 0, ev_bist = 0;
  logic [NP-1:0] part_st = '0, pmerr_st = '0, act_st = '0;
  logic [16*DW-1:0] cfg;
  logic phy_req, phy_write, phy_ack = 0;
  logic [4:0] phy_reg;
  logic [15:0] phy_wdata, phy_rdata = '0;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [DW-1:0] exp_q[$];
  string tag_q[$];

  always #5 clk = ~clk;

  sw_mgmt_regs #(.DW(DW), .NP(NP)) i_sw_mgmt_regs (
    .clk(clk), .rst_n(rst_n), .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_write_i(req_write), .req_addr_i(req_addr), .req_wdata_i(req_wdata),
    .rsp_valid_o(rsp_valid), .rsp_rdata_o(rsp_rdata),
    .init_done_i(ev_init), .partition_evt_i(ev_part), .arl_irq_i(ev_arl),
    .bist_fail_i(ev_bist), .part_status_i(part_st), .phy_err_status_i(pmerr_st),
    .activity_i(act_st), .irq_o(irq), .cfg_o(cfg), .phy_req_o(phy_req),
    .phy_write_o(phy_write), .phy_reg_o(phy_reg), .phy_wdata_o(phy_wdata),
    .phy_ack_i(phy_ack), .phy_rdata_i(phy_rdata)
  );

  task automatic chk(input bit ok, input string tag, input logic [DW-1:0] act,
                     input logic [DW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // PHY model: acknowledges after three waiting cycles
  int phy_cnt = 0;
  logic [4:0] phy_last_reg = '0;
  logic phy_last_wr = 0;
  logic [15:0] phy_last_wdata = '0;
  always @(negedge clk) begin
    phy_ack <= 1'b0;
    if (phy_req && !phy_ack) begin
      if (phy_cnt == 2) begin
        phy_ack        <= 1'b1;
        phy_rdata      <= 16'h1000 | 16'(phy_reg);
        phy_last_reg   <= phy_reg;
        phy_last_wr    <= phy_write;
        phy_last_wdata <= phy_wdata;
        phy_cnt        <= 0;
      end else phy_cnt <= phy_cnt + 1;
    end
  end

  // monitor: pops expected read data as responses appear
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (exp_q.size() == 0) chk(0, "R10 response without a read", rsp_rdata, '0);
      else begin
        logic [DW-1:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(rsp_rdata == e, t, rsp_rdata, e);
      end
    end
  end

  task automatic bus(input bit wr, input logic [5:0] a, input logic [DW-1:0] d,
                     input logic [DW-1:0] exp, input string tag, input bit ev,
                     output int stalls);
    @(negedge clk);
    req_valid = 1; req_write = wr; req_addr = a; req_wdata = d; ev_init = ev;
    stalls = 0;
    if (!wr) begin exp_q.push_back(exp); tag_q.push_back(tag); end
    #1;
    while (!req_ready) begin @(negedge clk); #1; stalls++; end
    @(posedge clk); #1;
    req_valid = 0; req_write = 0; ev_init = 0;
  endtask

  task automatic wr(input logic [5:0] a, input logic [DW-1:0] d);
    int s;
    bus(1, a, d, '0, "", 0, s);
  endtask

  task automatic rd(input logic [5:0] a, input logic [DW-1:0] exp, input string tag);
    int s;
    bus(0, a, '0, exp, tag, 0, s);
  endtask

  task automatic pulse(input int which);
    @(negedge clk);
    case (which)
      0: ev_init = 1;
      2: ev_part = 1;
      3: ev_arl  = 1;
      default: ev_bist = 1;
    endcase
    @(negedge clk);
    ev_init = 0; ev_part = 0; ev_arl = 0; ev_bist = 0;
    #1;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=%h expected=%h", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int s;
    logic [16*DW-1:0] saved;
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1 chk(irq == 0, "R1 irq after reset", DW'(irq), 0);
    rd(6'd1, 24'h0, "R1 cause after reset");
    rd(6'd2, 24'h0, "R1 error after reset");
    rd(6'd16, 24'h0, "R1 system word after reset");

    // R6 width masking
    wr(6'd16, 24'hFFFFFF); rd(6'd16, 24'h00FFFF, "R6 16-bit word");
    wr(6'd23, 24'hABCDEF); rd(6'd23, 24'h00000F, "R6 4-bit word");
    wr(6'd18, 24'h123456); rd(6'd18, 24'h123456, "R6 per-port word");
    wr(6'd25, 24'hFFFFFF); rd(6'd25, 24'h07FFFF, "R6 19-bit word");

    // R7 read-only and reserved addresses
    saved = cfg;
    wr(6'd1, 24'hFF); wr(6'd3, 24'hFFFF); wr(6'd0, 24'h55); wr(6'd10, 24'hAA);
    #1 chk(cfg == saved, "R7 config unchanged", cfg[DW-1:0], saved[DW-1:0]);
    rd(6'd0, 24'h0, "R7 reserved 0");
    rd(6'd10, 24'h0, "R7 reserved 10");
    rd(6'd1, 24'h0, "R7 cause not written");

    // R8 live status
    part_st = 24'hA5A5A5; pmerr_st = 24'h00005A; act_st = 24'h800001;
    rd(6'd3, 24'hA5A5A5, "R8 partition status");
    rd(6'd4, 24'h00005A, "R8 phy error status");
    rd(6'd5, 24'h800001, "R8 activity");

    // R2 / R3 sticky and clear on read
    pulse(0);
    rd(6'd1, 24'h01, "R2 init done bit");
    rd(6'd1, 24'h00, "R3 cleared after read");
    pulse(2); pulse(3);
    rd(6'd1, 24'h0C, "R2 partition and arl bits");

    // R4 error register and error enable
    pulse(4);
    rd(6'd2, 24'h01, "R4 bist bit");
    rd(6'd1, 24'h00, "R4 masked error no cause");
    wr(6'd30, 24'h000001);
    pulse(4);
    rd(6'd1, 24'h02, "R4 unmasked error sets cause");
    rd(6'd2, 24'h01, "R4 bist bit again");
    rd(6'd2, 24'h00, "R3 error cleared");

    // R5 interrupt masking
    wr(6'd17, 24'h000001);
    #1 chk(irq == 0, "R5 irq idle", DW'(irq), 0);
    pulse(0);
    chk(irq == 1, "R5 irq on enabled cause", DW'(irq), 1);
    rd(6'd1, 24'h01, "R5 cause read");
    #1 chk(irq == 0, "R5 irq drops after clear", DW'(irq), 0);
    pulse(3);
    chk(irq == 0, "R5 disabled cause no irq", DW'(irq), 0);
    rd(6'd1, 24'h08, "R5 disabled cause held");

    // R3 event on the clearing edge
    bus(0, 6'd1, '0, 24'h00, "R3 read with same-cycle event", 1, s);
    #1 chk(irq == 1, "R3 same-cycle event kept irq", DW'(irq), 1);
    rd(6'd1, 24'h01, "R3 same-cycle event survives");

    // R9 PHY window
    bus(0, 6'd37, '0, 24'h001005, "R9 phy read data", 0, s);
    chk(s > 0, "R9 stall before ack", DW'(s), 1);
    chk(phy_last_reg == 5'd5 && !phy_last_wr, "R9 phy read register",
        DW'(phy_last_reg), 24'd5);
    bus(1, 6'd63, 24'hABCD12, '0, "", 0, s);
    chk(phy_last_reg == 5'd31 && phy_last_wr, "R9 phy write register",
        DW'(phy_last_reg), 24'd31);
    chk(phy_last_wdata == 16'hCD12, "R9 phy write data", DW'(phy_last_wdata), 24'h00CD12);

    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, "R10 all reads answered", DW'(exp_q.size()), 0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule